// File: doc/BRIEF.md
# Counter Loop Branch Unit

This execution unit carries out one loop-primitive operation per accepted request. It picks one of six counter registers, optionally steps it by one, checks whether the result is zero, and decides whether a relative branch is taken. The branch condition, the step direction and the register are all chosen per request. The register file and the instruction decoder sit outside the block: the current register values come in on ports, and an updated counter leaves the block as a write-back request.

The counter registers come in two widths. The two accumulators are 8 bits wide and wrap within 8 bits. The double accumulator, the two index registers and the stack pointer are 16 bits wide. The branch target is the next-instruction address plus a 9-bit signed displacement, wrapped to 16 bits. The unit has no flag outputs, so the condition flags are never touched. Every result is registered and appears one cycle after the request.

Top module: `loop_branch_unit`

## Requirements
- R1: `sel_i` picks the counter: 0 = accumulator A (`a_i`), 1 = accumulator B (`b_i`), 2 = double accumulator (`d_i`), 3 = index X (`x_i`), 4 = index Y (`y_i`), 5 = stack pointer (`sp_i`).
- R2: `op_i` picks the operation: 0 = test only, 1 = decrement then test, 2 = increment then test, 3 = treated as test only. A test-only operation never raises `wr_en_o`.
- R3: For a decrement or increment on a valid counter, `wr_en_o` is 1, `wr_sel_o` repeats `sel_i`, and `wr_data_o` carries the stepped value. `wr_data_o` and `wr_sel_o` are meaningful only while `wr_en_o` is 1.
- R4: For codes 0 and 1, the step and the zero test use 8 bits with wrap-around (0x00-1 = 0xFF, 0xFF+1 = 0x00), and bits 15:8 of `wr_data_o` are 0.
- R5: For codes 2 to 5, the step and the zero test use 16 bits with wrap-around (0x0000-1 = 0xFFFF, 0xFFFF+1 = 0x0000).
- R6: The zero test looks at the value after the step (or at the unchanged value for test only). With `on_nz_i` = 0, `taken_o` is 1 when that value is zero; with `on_nz_i` = 1, `taken_o` is 1 when it is nonzero.
- R7: `target_o` = (`next_pc_i` + sign-extended `ofs_i`) mod 2^16. `ofs_i` is 9-bit two's complement, covering -256 to +255.
- R8: For `sel_i` codes 6 and 7, both `wr_en_o` and `taken_o` are 0.
- R9: Results appear on the clock edge after a cycle with `valid_i` = 1, with `valid_o` = 1. After a cycle with `valid_i` = 0, `valid_o`, `wr_en_o` and `taken_o` are 0.
- R10: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request present this cycle |
| sel_i | input | 3 | Counter register code |
| op_i | input | 2 | Operation code |
| on_nz_i | input | 1 | 0: branch on zero, 1: branch on nonzero |
| ofs_i | input | 9 | Signed branch displacement |
| next_pc_i | input | 16 | Address of next instruction |
| a_i | input | 8 | Accumulator A value |
| b_i | input | 8 | Accumulator B value |
| d_i | input | 16 | Double accumulator value |
| x_i | input | 16 | Index X value |
| y_i | input | 16 | Index Y value |
| sp_i | input | 16 | Stack pointer value |
| valid_o | output | 1 | Result present |
| wr_en_o | output | 1 | Counter write-back request |
| wr_sel_o | output | 3 | Counter code to write |
| wr_data_o | output | 16 | Updated counter value |
| taken_o | output | 1 | Branch taken |
| target_o | output | 16 | Branch target address |

## Verification
The assertions assume only that the request fields are stable at the sampling edge of any cycle where `valid_i` is 1. They accept every code on `sel_i` and `op_i`, including the unassigned ones. The stimulus drives inputs one time unit after the edge, so they always settle well before the next edge. It draws register codes across the whole 3-bit space and operation codes across the whole 2-bit space, so the unassigned and reserved codes occur often. Directed cases add the wrap points of both counter widths and the two ends of the displacement range.

// File: rtl/lb_pkg.sv
package lb_pkg;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned NARROW_W = 8;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned OP_W     = 2;
  localparam int unsigned OFS_W    = 9;
  localparam int unsigned ADDR_W   = 16;

  localparam logic [SEL_W-1:0] SEL_A  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_B  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_D  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_X  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_Y  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_SP = 3'd5;

  typedef enum logic [OP_W-1:0] {
    OP_TST = 2'd0,
    OP_DEC = 2'd1,
    OP_INC = 2'd2,
    OP_RSV = 2'd3
  } cnt_op_e;

  typedef struct packed {
    logic              wr;
    logic [SEL_W-1:0]  sel;
    logic [CNT_W-1:0]  val;
    logic              tk;
    logic [ADDR_W-1:0] tgt;
  } lb_res_t;
endpackage

// File: rtl/lb_cnt_select.sv
module lb_cnt_select
  import lb_pkg::*;
#(
  parameter int unsigned W  = CNT_W,
  parameter int unsigned NW = NARROW_W
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NW-1:0]    a_i,
  input  logic [NW-1:0]    b_i,
  input  logic [W-1:0]     d_i,
  input  logic [W-1:0]     x_i,
  input  logic [W-1:0]     y_i,
  input  logic [W-1:0]     sp_i,
  output logic [W-1:0]     cur_o,
  output logic             narrow_o,
  output logic             known_o
);
  localparam int unsigned PAD_W = W - NW;

  always_comb begin
    cur_o    = '0;
    narrow_o = 1'b0;
    known_o  = 1'b1;
    unique case (sel_i)
      SEL_A:  begin cur_o = {{PAD_W{1'b0}}, a_i}; narrow_o = 1'b1; end
      SEL_B:  begin cur_o = {{PAD_W{1'b0}}, b_i}; narrow_o = 1'b1; end
      SEL_D:  cur_o = d_i;
      SEL_X:  cur_o = x_i;
      SEL_Y:  cur_o = y_i;
      SEL_SP: cur_o = sp_i;
      default: known_o = 1'b0;
    endcase
  end

  // R8
  unknown_sel_chk: assert final (known_o || (sel_i > SEL_SP));
endmodule

// File: rtl/lb_cnt_step.sv
module lb_cnt_step
  import lb_pkg::*;
#(
  parameter int unsigned W  = CNT_W,
  parameter int unsigned NW = NARROW_W
) (
  input  logic [W-1:0]    cur_i,
  input  logic            narrow_i,
  input  cnt_op_e         op_i,
  output logic [W-1:0]    nxt_o,
  output logic            zero_o,
  output logic            step_o
);
  localparam logic [W-1:0] ONE       = W'(1);
  localparam logic [W-1:0] MASK_NARR = {{(W-NW){1'b0}}, {NW{1'b1}}};

  logic [W-1:0] raw, mask;

  always_comb begin
    unique case (op_i)
      OP_DEC:  raw = cur_i - ONE;
      OP_INC:  raw = cur_i + ONE;
      default: raw = cur_i;
    endcase
  end

  assign mask   = narrow_i ? MASK_NARR : '1;
  assign nxt_o  = raw & mask;
  assign zero_o = (nxt_o == '0);
  assign step_o = (op_i == OP_DEC) || (op_i == OP_INC);
endmodule

// File: rtl/lb_tgt_add.sv
module lb_tgt_add
  import lb_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned OW = OFS_W
) (
  input  logic [AW-1:0] pc_i,
  input  logic [OW-1:0] ofs_i,
  output logic [AW-1:0] tgt_o
);
  logic [AW-1:0] ofs_ext;

  generate
    if (AW > OW) begin : g_ext
      assign ofs_ext = {{(AW-OW){ofs_i[OW-1]}}, ofs_i};
    end else begin : g_trunc
      assign ofs_ext = ofs_i[AW-1:0];
    end
  endgenerate

  assign tgt_o = pc_i + ofs_ext;
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
  import lb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              on_nz_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  input  logic [NARROW_W-1:0] a_i,
  input  logic [NARROW_W-1:0] b_i,
  input  logic [CNT_W-1:0]  d_i,
  input  logic [CNT_W-1:0]  x_i,
  input  logic [CNT_W-1:0]  y_i,
  input  logic [CNT_W-1:0]  sp_i,
  output logic              valid_o,
  output logic              wr_en_o,
  output logic [SEL_W-1:0]  wr_sel_o,
  output logic [CNT_W-1:0]  wr_data_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o
);
  logic [CNT_W-1:0]  cur, nxt;
  logic              narrow, known, zero, step;
  logic [ADDR_W-1:0] tgt;
  lb_res_t           res_d, res_q;
  logic              vld_q;
  cnt_op_e           op;

  assign op = cnt_op_e'(op_i);

  lb_cnt_select u_sel (
    .sel_i(sel_i), .a_i(a_i), .b_i(b_i), .d_i(d_i), .x_i(x_i),
    .y_i(y_i), .sp_i(sp_i), .cur_o(cur), .narrow_o(narrow), .known_o(known)
  );

  lb_cnt_step u_step (
    .cur_i(cur), .narrow_i(narrow), .op_i(op),
    .nxt_o(nxt), .zero_o(zero), .step_o(step)
  );

  lb_tgt_add u_tgt (.pc_i(next_pc_i), .ofs_i(ofs_i), .tgt_o(tgt));

  always_comb begin
    res_d.wr  = valid_i && known && step;
    res_d.sel = sel_i;
    res_d.val = nxt;
    res_d.tk  = valid_i && known && (on_nz_i ? !zero : zero);
    res_d.tgt = tgt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= valid_i;
      res_q <= res_d;
    end
  end

  assign valid_o   = vld_q;
  assign wr_en_o   = res_q.wr;
  assign wr_sel_o  = res_q.sel;
  assign wr_data_o = res_q.val;
  assign taken_o   = res_q.tk;
  assign target_o  = res_q.tgt;

  // R9
  wr_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o || taken_o) |-> valid_o);

  // R2
  test_no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == OP_TST || op_i == OP_RSV)) |=> !wr_en_o);

  // R8
  bad_sel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sel_i > SEL_SP) |=> (!wr_en_o && !taken_o));

  // R4
  narrow_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_sel_o <= SEL_B) |-> (wr_data_o[CNT_W-1:NARROW_W] == '0));

  // R6
  zero_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !on_nz_i && sel_i <= SEL_SP && (op_i == OP_DEC || op_i == OP_INC))
    |=> (taken_o == (wr_data_o == '0)));

  // R3
  wr_sel_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sel_i <= SEL_SP && (op_i == OP_DEC || op_i == OP_INC))
    |=> (wr_en_o && wr_sel_o == $past(sel_i)));
endmodule

// File: tb/sim_loop_branch_unit.sv
`timescale 1ns/1ps
module sim_loop_branch_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic valid, on_nz;
  logic [2:0] sel;
  logic [1:0] op;
  logic [8:0] ofs;
  logic [15:0] pc, d, x, y, sp;
  logic [7:0] a, b;
  logic vo, we, tk;
  logic [2:0] ws;
  logic [15:0] wd, tg;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  loop_branch_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sel_i(sel), .op_i(op),
    .on_nz_i(on_nz), .ofs_i(ofs), .next_pc_i(pc), .a_i(a), .b_i(b),
    .d_i(d), .x_i(x), .y_i(y), .sp_i(sp), .valid_o(vo), .wr_en_o(we),
    .wr_sel_o(ws), .wr_data_o(wd), .taken_o(tk), .target_o(tg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] cur_of(input logic [2:0] s);
    case (s)
      3'd0: return {8'h00, a};
      3'd1: return {8'h00, b};
      3'd2: return d;
      3'd3: return x;
      3'd4: return y;
      3'd5: return sp;
      default: return 16'h0;
    endcase
  endfunction

  task automatic run(input logic [2:0] s, input logic [1:0] o, input logic nz,
                     input logic [8:0] of, input logic [15:0] p);
    int cv, nv, msk;
    logic known, step, zero, e_wr, e_tk;
    logic [15:0] e_tg;
    sel = s; op = o; on_nz = nz; ofs = of; pc = p; valid = 1'b1;
    known = (s <= 3'd5);
    step  = (o == 2'd1) || (o == 2'd2);
    msk   = (s <= 3'd1) ? 32'hFF : 32'hFFFF;
    cv    = int'(cur_of(s));
    nv    = (o == 2'd1) ? cv - 1 : (o == 2'd2) ? cv + 1 : cv;
    nv    = nv & msk;
    zero  = (nv == 0);
    e_wr  = known && step;
    e_tk  = known && (nz ? !zero : zero);
    e_tg  = 16'(int'(p) + int'($signed(of)));
    @(posedge clk); #1;
    valid = 1'b0;
    chk("R9 valid_o", 32'(vo), 32'd1);
    chk(known ? "R2 wr_en_o" : "R8 wr_en_o", 32'(we), 32'(e_wr));
    chk(known ? "R6 taken_o" : "R8 taken_o", 32'(tk), 32'(e_tk));
    chk("R7 target_o", 32'(tg), 32'(e_tg));
    if (e_wr) begin
      chk((s <= 3'd1) ? "R4 wr_data_o" : "R5 wr_data_o", 32'(wd), 32'(nv));
      chk("R3 wr_sel_o", 32'(ws), 32'(s));
    end
  endtask

  initial begin
    valid = 0; sel = 0; op = 0; on_nz = 0; ofs = 0; pc = 0;
    a = 0; b = 0; d = 0; x = 0; y = 0; sp = 0;
    #12;
    // R10
    chk("R10 valid_o", 32'(vo), 0);
    chk("R10 wr_en_o", 32'(we), 0);
    chk("R10 taken_o", 32'(tk), 0);
    chk("R10 target_o", 32'(tg), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;

    // R4 narrow wrap points
    a = 8'h00; run(3'd0, 2'd1, 1'b1, 9'd4, 16'h1000);
    b = 8'hFF; run(3'd1, 2'd2, 1'b0, 9'd4, 16'h1000);
    a = 8'h01; run(3'd0, 2'd1, 1'b0, 9'h1F0, 16'h2000);
    // R5 wide wrap points
    d = 16'h0000; run(3'd2, 2'd1, 1'b1, 9'd0, 16'h3000);
    x = 16'hFFFF; run(3'd3, 2'd2, 1'b0, 9'd0, 16'h3000);
    y = 16'h00FF; run(3'd4, 2'd2, 1'b0, 9'd0, 16'h3000);
    sp = 16'h0001; run(3'd5, 2'd1, 1'b0, 9'd0, 16'h3000);
    // R1 R2 test only, reserved op
    x = 16'h0000; run(3'd3, 2'd0, 1'b0, 9'd8, 16'h4000);
    d = 16'h0100; run(3'd2, 2'd3, 1'b1, 9'd8, 16'h4000);
    // R7 offset extremes with wrap
    run(3'd2, 2'd0, 1'b1, 9'h0FF, 16'hFFF0);
    run(3'd2, 2'd0, 1'b1, 9'h100, 16'h0005);
    // R8 unassigned codes
    run(3'd6, 2'd1, 1'b0, 9'd1, 16'h5000);
    run(3'd7, 2'd2, 1'b1, 9'd1, 16'h5000);

    // R9 idle cycle
    @(posedge clk); #1;
    chk("R9 idle valid_o", 32'(vo), 0);
    chk("R9 idle wr_en_o", 32'(we), 0);
    chk("R9 idle taken_o", 32'(tk), 0);

    void'($urandom(32'd2024));
    for (int i = 0; i < 1500; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      a  = (r[1:0] == 0) ? 8'h00 : (r[1:0] == 1) ? 8'h01 : 8'($urandom);
      b  = (r[3:2] == 0) ? 8'hFF : 8'($urandom);
      d  = (r[5:4] == 0) ? 16'h0001 : 16'($urandom);
      x  = (r[7:6] == 0) ? 16'hFFFF : 16'($urandom);
      y  = (r[9:8] == 0) ? 16'h0000 : 16'($urandom);
      sp = 16'($urandom);
      run(3'($urandom), 2'($urandom), 1'($urandom), 9'($urandom), 16'($urandom));
      if (r[15:12] == 0) begin
        @(posedge clk); #1;
        chk("R9 gap wr_en_o", 32'(we), 0);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule